// File: doc/BRIEF.md
# Serial Shift Register with Output Latch

This block is an 8-bit data register that can be loaded and read in parallel and also shifted one place toward its most significant bit on each clock event. The new least significant bit comes from a serial data input. A 2-bit select field picks the event source: a software strobe, a timer overflow pulse, or the rising or falling edge of an external serial clock. There is no holding buffer. The parallel read port shows the live register, and a parallel write lands in that same register.

Bit 7 drives the serial output through a latch. When an external clock is selected, the latch passes data only during the half of the serial clock period before the sampling edge, and holds its value during the other half. This keeps output changes and input sampling on opposite serial clock edges. With an internal source the latch is always transparent, so a new MSB reaches the output at once. An output-enable input gates the serial output, in the way a pin direction setting would.

The whole block runs on one system clock. The external serial clock and serial data pass through two-flop synchronizers. Edges are detected on the synchronized clock.

Top module: `serial_shift_latch`

## Requirements
- R1: After reset, `regData` is 0x00 and `serDataOut` is 0.
- R2: A cycle with `wrEn` high loads `wrData` into the register. `regData` shows the new value after that clock edge, and at all times it shows the live register.
- R3: A shift event sets the register to {bits 6..0, synchronized `serDataIn`}. With `clkSel`=0 (software), each cycle with `swStrobe` high is one event. In this mode `timerOvf` and serial clock edges have no effect.
- R4: With `clkSel`=1 (timer), each cycle with `timerOvf` high is one shift event. In this mode `swStrobe` and serial clock edges have no effect.
- R5: If a write and a shift event fall in the same cycle, the written value is kept and no shift takes place.
- R6: With `clkSel`=2, a rising edge of `serClkIn` shifts the register three system clocks after it arrives (two synchronizer stages plus the register). The output latch is transparent while the synchronized serial clock is low.
- R7: While the latch is closed, `serDataOut` keeps its value even if bit 7 changes through a shift or a write. The latch shows the current bit 7 once it opens again.
- R8: With an internal source (`clkSel`=0 or 1), `serDataOut` equals bit 7 of `regData` in every cycle, including the cycle right after a write.
- R9: When `outEn` is 0, `serDataOut` is 0 whatever the register holds.
- R10: With `clkSel`=3, a falling edge of `serClkIn` shifts the register, and the latch is transparent while the synchronized serial clock is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| serDataIn | input | 1 | Serial data in (asynchronous, synchronized inside) |
| serClkIn | input | 1 | External serial clock (asynchronous, synchronized inside) |
| clkSel | input | 2 | Event source: 0 software, 1 timer, 2 external rising, 3 external falling |
| timerOvf | input | 1 | Single-cycle timer overflow pulse |
| swStrobe | input | 1 | Single-cycle software shift strobe |
| wrEn | input | 1 | Parallel write enable |
| wrData | input | 8 | Parallel write data |
| outEn | input | 1 | Serial output enable |
| serDataOut | output | 1 | Latched, gated MSB |
| regData | output | 8 | Live register contents |

## Verification
The assertions assume that `swStrobe` and `timerOvf` are synchronous to `clk`. They also assume that `clkSel` does not change in the same cycle as a detected serial clock edge, so that each edge is read against one selection. The bench drives every input on the falling edge of `clk`. It holds each serial clock level for five system clocks, sets serial data at least three cycles before the event that samples it, and changes `clkSel` only while the serial clock is idle. This keeps synchronizer latency out of the expected values.

// File: rtl/ssl_pkg.sv
package ssl_pkg;
  typedef enum logic [1:0] {
    SEL_SW       = 2'd0,
    SEL_TIMER    = 2'd1,
    SEL_EXT_RISE = 2'd2,
    SEL_EXT_FALL = 2'd3
  } clkSelT;

  typedef struct packed {
    logic shift;      // one shift event this cycle
    logic latchOpen;  // output latch transparent this cycle
  } sslStrobeT;
endpackage

// File: rtl/ssl_sync.sv
module ssl_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic asyncIn,
  output logic syncOut
);
  logic [STAGES-1:0] chain;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge rstN)
        if (!rstN) chain <= '0;
        else       chain <= asyncIn;
    end else begin : g_multi
      always_ff @(posedge clk or negedge rstN)
        if (!rstN) chain <= '0;
        else       chain <= {chain[STAGES-2:0], asyncIn};
    end
  endgenerate

  assign syncOut = chain[STAGES-1];
endmodule

// File: rtl/ssl_ctrl.sv
module ssl_ctrl
  import ssl_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      serClkIn,
  input  logic      serDataIn,
  input  logic [1:0] clkSel,
  input  logic      timerOvf,
  input  logic      swStrobe,
  output sslStrobeT ctl,
  output logic      syncData
);
  logic syncClk;
  logic prevClk;
  logic riseEdge;
  logic fallEdge;
  clkSelT sel;

  ssl_sync #(.STAGES(SYNC_STAGES)) uClkSync (
    .clk(clk), .rstN(rstN), .asyncIn(serClkIn), .syncOut(syncClk)
  );
  ssl_sync #(.STAGES(SYNC_STAGES)) uDataSync (
    .clk(clk), .rstN(rstN), .asyncIn(serDataIn), .syncOut(syncData)
  );

  always_ff @(posedge clk or negedge rstN)
    if (!rstN) prevClk <= 1'b0;
    else       prevClk <= syncClk;

  assign riseEdge = syncClk & ~prevClk;
  assign fallEdge = ~syncClk & prevClk;
  assign sel      = clkSelT'(clkSel);

  always_comb begin
    ctl = '0;
    unique case (sel)
      SEL_SW: begin
        ctl.shift     = swStrobe;
        ctl.latchOpen = 1'b1;
      end
      SEL_TIMER: begin
        ctl.shift     = timerOvf;
        ctl.latchOpen = 1'b1;
      end
      SEL_EXT_RISE: begin
        ctl.shift     = riseEdge;
        ctl.latchOpen = ~syncClk;
      end
      SEL_EXT_FALL: begin
        ctl.shift     = fallEdge;
        ctl.latchOpen = syncClk;
      end
      default: ctl = '0;
    endcase
  end

  // Two edges of the same polarity can never be back to back.
  p_edge_spacing_r6: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.shift && clkSel[1]) |=> !(ctl.shift && clkSel == $past(clkSel)));
endmodule

// File: rtl/ssl_datapath.sv
module ssl_datapath
  import ssl_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  sslStrobeT        ctl,
  input  logic             syncData,
  input  logic             internalSrc,
  input  logic             wrEn,
  input  logic [WIDTH-1:0] wrData,
  output logic [WIDTH-1:0] regData,
  output logic             latchOut
);
  localparam int MSB = WIDTH - 1;

  logic [WIDTH-1:0] shiftReg;
  logic             latchQ;

  always_ff @(posedge clk or negedge rstN)
    if (!rstN)          shiftReg <= '0;
    else if (wrEn)      shiftReg <= wrData;
    else if (ctl.shift) shiftReg <= {shiftReg[MSB-1:0], syncData};

  always_ff @(posedge clk or negedge rstN)
    if (!rstN)              latchQ <= 1'b0;
    else if (ctl.latchOpen) latchQ <= shiftReg[MSB];

  assign latchOut = ctl.latchOpen ? shiftReg[MSB] : latchQ;
  assign regData  = shiftReg;

  p_write_wins_r5: assert property (@(posedge clk) disable iff (!rstN)
    wrEn |=> regData == $past(wrData));

  p_shift_r3: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.shift && !wrEn) |=> regData == {$past(regData[MSB-1:0]), $past(syncData)});

  p_hold_r2: assert property (@(posedge clk) disable iff (!rstN)
    (!ctl.shift && !wrEn) |=> $stable(regData));

  p_latch_hold_r7: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.latchOpen |=> (ctl.latchOpen || $stable(latchOut)));

  p_open_internal_r8: assert property (@(posedge clk) disable iff (!rstN)
    internalSrc |-> (ctl.latchOpen && latchOut == regData[MSB]));
endmodule

// File: rtl/serial_shift_latch.sv
module serial_shift_latch
  import ssl_pkg::*;
#(
  parameter int WIDTH       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             serDataIn,
  input  logic             serClkIn,
  input  logic [1:0]       clkSel,
  input  logic             timerOvf,
  input  logic             swStrobe,
  input  logic             wrEn,
  input  logic [WIDTH-1:0] wrData,
  input  logic             outEn,
  output logic             serDataOut,
  output logic [WIDTH-1:0] regData
);
  sslStrobeT ctl;
  logic      syncData;
  logic      latchOut;

  ssl_ctrl #(.SYNC_STAGES(SYNC_STAGES)) uCtrl (
    .clk(clk), .rstN(rstN), .serClkIn(serClkIn), .serDataIn(serDataIn),
    .clkSel(clkSel), .timerOvf(timerOvf), .swStrobe(swStrobe),
    .ctl(ctl), .syncData(syncData)
  );

  ssl_datapath #(.WIDTH(WIDTH)) uData (
    .clk(clk), .rstN(rstN), .ctl(ctl), .syncData(syncData),
    .internalSrc(~clkSel[1]), .wrEn(wrEn), .wrData(wrData),
    .regData(regData), .latchOut(latchOut)
  );

  assign serDataOut = outEn & latchOut;

  p_gate_off_r9: assert property (@(posedge clk) disable iff (!rstN)
    (!outEn && regData[WIDTH-1]) |-> !serDataOut);
endmodule

// File: tb/serial_shift_latch_test.sv
module serial_shift_latch_test;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic serDataIn = 1'b0, serClkIn = 1'b0;
  logic [1:0] clkSel = 2'd0;
  logic timerOvf = 1'b0, swStrobe = 1'b0, wrEn = 1'b0, outEn = 1'b1;
  logic [7:0] wrData = 8'd0;
  logic serDataOut;
  logic [7:0] regData;

  int checks = 0, errors = 0;
  bit done = 0;
  logic [7:0] expReg = 8'd0;
  logic expOut;

  always #2.5 clk = ~clk;

  serial_shift_latch uut (
    .clk(clk), .rstN(rstN), .serDataIn(serDataIn), .serClkIn(serClkIn),
    .clkSel(clkSel), .timerOvf(timerOvf), .swStrobe(swStrobe), .wrEn(wrEn),
    .wrData(wrData), .outEn(outEn), .serDataOut(serDataOut), .regData(regData)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic doWrite(input logic [7:0] v);
    @(negedge clk); wrEn = 1'b1; wrData = v;
    @(negedge clk); wrEn = 1'b0;
    expReg = v;
  endtask

  task automatic setDin(input logic b);
    serDataIn = b;
    repeat (3) @(negedge clk);
  endtask

  task automatic pulseSw(input logic b);
    setDin(b);
    swStrobe = 1'b1; @(negedge clk); swStrobe = 1'b0;
  endtask

  task automatic pulseTimer(input logic b);
    setDin(b);
    timerOvf = 1'b1; @(negedge clk); timerOvf = 1'b0;
  endtask

  task automatic extLevel(input logic lvl);
    serClkIn = lvl;
    repeat (5) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 regData", regData, 0);
    chk("R1 serDataOut", serDataOut, 0);

    // R2 / R8: every value written, output follows bit 7 at once
    for (int v = 0; v < 256; v++) begin
      doWrite(v[7:0]);
      chk("R2 write", regData, v);
      chk("R8 out follows msb", serDataOut, v[7]);
    end

    // R3: software strobe shifting over several patterns
    for (int p = 0; p < 256; p += 37) begin
      doWrite(8'h00);
      for (int i = 7; i >= 0; i--) begin
        pulseSw(p[i]);
        expReg = {expReg[6:0], p[i]};
        chk("R3 sw shift", regData, expReg);
        chk("R8 out after shift", serDataOut, expReg[7]);
      end
      chk("R3 pattern", regData, p);
    end
    // R3: timer and serial clock ignored in mode 0
    doWrite(8'h5A);
    pulseTimer(1'b1);
    extLevel(1'b1); extLevel(1'b0);
    chk("R3 others ignored", regData, 8'h5A);

    // R4: timer source
    clkSel = 2'd1;
    for (int p = 3; p < 256; p += 50) begin
      doWrite(8'hFF);
      for (int i = 7; i >= 0; i--) begin
        pulseTimer(p[i]);
        expReg = {expReg[6:0], p[i]};
      end
      chk("R4 timer pattern", regData, p);
    end
    pulseSw(1'b1);
    extLevel(1'b1); extLevel(1'b0);
    chk("R4 sw and clk ignored", regData, expReg);

    // R5: collision, write wins (timer and software)
    setDin(1'b1);
    @(negedge clk); wrEn = 1'b1; wrData = 8'h3C; timerOvf = 1'b1;
    @(negedge clk); wrEn = 1'b0; timerOvf = 1'b0;
    chk("R5 timer collision", regData, 8'h3C);
    clkSel = 2'd0;
    @(negedge clk); wrEn = 1'b1; wrData = 8'hC3; swStrobe = 1'b1;
    @(negedge clk); wrEn = 1'b0; swStrobe = 1'b0;
    chk("R5 sw collision", regData, 8'hC3);

    // R6 / R7: external rising edge, latch open while low
    clkSel = 2'd2;
    doWrite(8'hB4);
    for (int i = 0; i < 8; i++) begin
      logic b;
      b = (8'h6D >> i) & 1'b1;
      setDin(b);
      chk("R6 out before edge", serDataOut, expReg[7]);
      expOut = expReg[7];
      extLevel(1'b1);
      expReg = {expReg[6:0], b};
      chk("R6 rise shift", regData, expReg);
      chk("R7 held while closed", serDataOut, expOut);
      extLevel(1'b0);
      chk("R6 out after open", serDataOut, expReg[7]);
    end
    // R7: write while latch closed
    doWrite(8'h00);
    extLevel(1'b1);
    expReg = {expReg[6:0], serDataIn};
    doWrite(8'h80);
    chk("R7 write while closed", serDataOut, 0);
    chk("R2 write in ext mode", regData, 8'h80);
    extLevel(1'b0);
    chk("R7 shows on reopen", serDataOut, 1);

    // R9: output gating
    outEn = 1'b0;
    @(negedge clk);
    chk("R9 gated", serDataOut, 0);
    outEn = 1'b1;
    @(negedge clk);
    chk("R9 enabled", serDataOut, 1);

    // R10: external falling edge, latch open while high
    clkSel = 2'd3;
    extLevel(1'b1);
    chk("R10 rise ignored", regData, 8'h80);
    doWrite(8'h2F);
    for (int i = 0; i < 8; i++) begin
      logic b;
      b = (8'h97 >> i) & 1'b1;
      setDin(b);
      chk("R10 out before edge", serDataOut, expReg[7]);
      expOut = expReg[7];
      extLevel(1'b0);
      expReg = {expReg[6:0], b};
      chk("R10 fall shift", regData, expReg);
      chk("R7 held low phase", serDataOut, expOut);
      extLevel(1'b1);
      chk("R10 out after open", serDataOut, expReg[7]);
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule